// File: doc/BRIEF.md
# Opcode-Driven Half-Duplex SPI Command Engine

This block is an SPI master driven by commands over a byte-wide register window. Software picks one of four chip-select lines and writes a one-byte command opcode. It places the outgoing payload in a 64-byte shared buffer and programs how many bytes to write and how many to read. Setting the start bit then runs the command. While the command runs, the engine drives the chosen select line low and sends the opcode, then the payload, most significant bit first. It then clocks in the requested number of reply bytes. A status bit reports when the command is running.

The reply bytes go back into the same buffer, directly behind the bytes that were sent. The buffer is used through an internal byte pointer, and a pointer-reset bit sets that pointer back to entry 0. The serial clock is the system clock divided by `CLK_DIV`, idles low, and uses SPI mode 0.

Top module: `spi_opcode_master`

## Requirements
- R1: After a synchronous active-low reset, every register and every buffer entry reads 0, the start/busy byte at 0x03 reads 0, all select lines are high, the serial clock is low and the data-out line is high.
- R2: A command first sends the opcode held at address 0x00, most significant bit first. Data-out changes only while the serial clock is low, so it is stable at every rising edge.
- R3: After the opcode, the engine sends the number of bytes given by address 0x48. It reads them in order from the buffer (buffer entry i sits at address 0x80+i), starting at the internal pointer.
- R4: After the sent bytes, the engine clocks in the number of bytes given by address 0x4B. During this phase data-out is held high. Reply byte j is stored at buffer entry pointer+tx_count+j. Input data seen during the opcode and send phases changes no buffer entry.
- R5: Bit 7 of address 0x03 (control bit 31) reads 1 from the cycle after a start until the command has finished, and then reads 0.
- R6: Writing a byte with bit 0 set to address 0x02 (control bit 16) starts a command when the engine is idle. A start written while busy has no effect. The start bit and the pointer-reset bit (bit 4 of address 0x02, control bit 20) always read back 0.
- R7: The pointer-reset bit sets the internal pointer to entry 0. Without it, the next command continues from the entry where the previous command stopped.
- R8: Bits [1:0] of address 0x1D choose which of the four active-low select lines is driven low during a command. No other line goes low, and the chosen line does not change during the command.
- R9: The serial clock period is `CLK_DIV` system cycles, and the clock toggles only while a select line is low. The select line goes low at least one serial clock period before the first rising edge and goes high at least one period after the last falling edge. The total number of rising edges is 8*(1+tx_count+rx_count).
- R10: The pointer stops at the buffer depth. A byte to be sent from beyond the buffer goes out as 0xFF, and a reply byte that would land beyond the buffer is dropped without wrapping to entry 0.
- R11: Bus writes into the buffer while the engine is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register window |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Active-low select lines |

## Verification
A wrong pointer shows up within one command. The bytes that follow the opcode on data-out come from the wrong buffer entries, and the reply bytes land at the wrong addresses, which a readback of the whole buffer exposes. A sequencer or divider fault changes the number or spacing of serial clock edges within the first byte. A start that is not ignored while busy stretches the edge count of that same command. The bench models the buffer and the pointer on its own and compares every captured byte, every buffer entry and the edge timing after each command.

// File: rtl/spi_cmd_pkg.sv
// Shared types and register offsets for the SPI command engine.
// Assumes an 8-bit byte-addressed register window.
package spi_cmd_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_XFER, ST_TRAIL} eng_state_t;
    typedef enum logic [1:0] {BK_OP, BK_TX, BK_RX} byte_kind_t;

    localparam logic [7:0] A_OPCODE = 8'h00;
    localparam logic [7:0] A_CTRL2  = 8'h02;
    localparam logic [7:0] A_CTRL3  = 8'h03;
    localparam logic [7:0] A_CSSEL  = 8'h1D;
    localparam logic [7:0] A_TXCNT  = 8'h48;
    localparam logic [7:0] A_RXCNT  = 8'h4B;
    localparam logic [7:0] A_BUF    = 8'h80;
endpackage

// File: rtl/spi_cmd_fifo.sv
// Byte buffer shared by the bus and the engine: one write port, two
// combinational read ports. Assumes callers keep indices below DEPTH.
module spi_cmd_fifo #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [7:0]       rd_a_data,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [7:0]       rd_b_data
);
    logic [7:0] mem [DEPTH];

    // Storage update: clear on reset, else take the single write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_a_data = mem[rd_a_idx];
    assign rd_b_data = mem[rd_b_idx];
endmodule

// File: rtl/spi_cmd_regs.sv
// Byte-wide register window: opcode, counts, select, start/clear pulses,
// busy readback and buffer access. Assumes A_BUF + DEPTH <= 256.
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int SEL_W = 2,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int BUF_END = int'(A_BUF) + DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    input  logic             bus_we,
    output logic [7:0]       bus_rdata,
    input  logic             busy,
    output logic [7:0]       opcode,
    output logic [7:0]       tx_count,
    output logic [7:0]       rx_count,
    output logic [SEL_W-1:0] cs_sel,
    output logic             start,
    output logic             ptr_clr,
    output logic             buf_we,
    output logic [IDX_W-1:0] buf_idx,
    input  logic [7:0]       buf_rdata
);
    logic in_buf;

    assign in_buf  = (int'(bus_addr) >= int'(A_BUF)) && (int'(bus_addr) < BUF_END);
    assign buf_idx = IDX_W'(bus_addr - A_BUF);
    assign buf_we  = bus_we && in_buf && !busy;
    assign start   = bus_we && (bus_addr == A_CTRL2) && bus_wdata[0] && !busy;
    assign ptr_clr = bus_we && (bus_addr == A_CTRL2) && bus_wdata[4] && !busy;

    // Configuration registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode   <= '0;
            tx_count <= '0;
            rx_count <= '0;
            cs_sel   <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                A_OPCODE: opcode   <= bus_wdata;
                A_TXCNT:  tx_count <= bus_wdata;
                A_RXCNT:  rx_count <= bus_wdata;
                A_CSSEL:  cs_sel   <= bus_wdata[SEL_W-1:0];
                default:  ;
            endcase
        end
    end

    // Read multiplexer; pulse bits read as 0.
    always_comb begin
        bus_rdata = '0;
        if (in_buf) begin
            bus_rdata = buf_rdata;
        end else begin
            case (bus_addr)
                A_OPCODE: bus_rdata = opcode;
                A_CTRL3:  bus_rdata = {busy, 7'b0};
                A_TXCNT:  bus_rdata = tx_count;
                A_RXCNT:  bus_rdata = rx_count;
                A_CSSEL:  bus_rdata = 8'(cs_sel);
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/spi_cmd_engine.sv
// Command sequencer and mode-0 shifter: select lead, opcode, send bytes,
// reply bytes, select lag. Assumes CLK_DIV is even and at least 2.
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int CLK_DIV = 4,
    parameter int NUM_CS  = 4,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int PTR_W  = $clog2(DEPTH + 1),
    localparam int SEL_W  = $clog2(NUM_CS),
    localparam int HALF   = CLK_DIV / 2,
    localparam int DIV_W  = $clog2(CLK_DIV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ptr_clr,
    input  logic [7:0]        opcode,
    input  logic [7:0]        tx_count,
    input  logic [7:0]        rx_count,
    input  logic [SEL_W-1:0]  cs_sel,
    output logic              busy,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [7:0]        rd_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [7:0]        wr_data,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n
);
    eng_state_t       state;
    byte_kind_t       kind;
    logic [DIV_W-1:0] div_cnt;
    logic [2:0]       bit_cnt;
    logic [7:0]       tx_left, rx_left, tx_sh, rx_sh;
    logic [PTR_W-1:0] ptr, ptr_inc, ptr_adv;
    logic [SEL_W-1:0] sel_q;
    logic             sclk_q, div_last, div_mid, byte_end;
    logic [7:0]       next_tx;

    assign div_last = div_cnt == DIV_W'(CLK_DIV - 1);
    assign div_mid  = div_cnt == DIV_W'(HALF - 1);
    assign byte_end = (state == ST_XFER) && div_last && (bit_cnt == 3'd0);
    assign ptr_inc  = (ptr == PTR_W'(DEPTH)) ? ptr : ptr + 1'b1;
    assign ptr_adv  = (kind == BK_OP) ? ptr : ptr_inc;
    assign rd_idx   = IDX_W'(ptr_adv);
    assign next_tx  = (ptr_adv == PTR_W'(DEPTH)) ? 8'hFF : rd_data;

    assign wr_en   = byte_end && (kind == BK_RX) && (ptr < PTR_W'(DEPTH));
    assign wr_idx  = IDX_W'(ptr);
    assign wr_data = rx_sh;

    assign busy = state != ST_IDLE;
    assign sclk = sclk_q;
    assign mosi = busy ? tx_sh[7] : 1'b1;
    assign cs_n = busy ? ~(NUM_CS'(1) << sel_q) : '1;

    // Sequencer, clock divider, shifters and buffer pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            kind    <= BK_OP;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_left <= '0;
            rx_left <= '0;
            tx_sh   <= 8'hFF;
            rx_sh   <= '0;
            ptr     <= '0;
            sel_q   <= '0;
            sclk_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    sclk_q <= 1'b0;
                    if (ptr_clr) ptr <= '0;
                    if (start) begin
                        state   <= ST_LEAD;
                        div_cnt <= '0;
                        tx_sh   <= opcode;
                        bit_cnt <= 3'd7;
                        kind    <= BK_OP;
                        tx_left <= tx_count;
                        rx_left <= rx_count;
                        sel_q   <= cs_sel;
                    end
                end
                ST_LEAD: begin
                    div_cnt <= div_last ? '0 : div_cnt + 1'b1;
                    if (div_last) state <= ST_XFER;
                end
                ST_XFER: begin
                    div_cnt <= div_last ? '0 : div_cnt + 1'b1;
                    if (div_mid) begin
                        sclk_q <= 1'b1;
                        rx_sh  <= {rx_sh[6:0], miso};
                    end
                    if (div_last) begin
                        sclk_q <= 1'b0;
                        if (bit_cnt != 3'd0) begin
                            bit_cnt <= bit_cnt - 1'b1;
                            tx_sh   <= {tx_sh[6:0], 1'b1};
                        end else begin
                            ptr     <= ptr_adv;
                            bit_cnt <= 3'd7;
                            if (tx_left != 8'd0) begin
                                tx_sh   <= next_tx;
                                kind    <= BK_TX;
                                tx_left <= tx_left - 1'b1;
                            end else if (rx_left != 8'd0) begin
                                tx_sh   <= 8'hFF;
                                kind    <= BK_RX;
                                rx_left <= rx_left - 1'b1;
                            end else begin
                                tx_sh <= 8'hFF;
                                state <= ST_TRAIL;
                            end
                        end
                    end
                end
                ST_TRAIL: begin
                    div_cnt <= div_last ? '0 : div_cnt + 1'b1;
                    if (div_last) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_opcode_master.sv
// Top of the opcode-driven half-duplex SPI engine: register window,
// shared byte buffer and sequencer. Assumes a single clock domain.
module spi_opcode_master #(
    parameter int DEPTH   = 64,
    parameter int CLK_DIV = 4,
    parameter int NUM_CS  = 4,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int SEL_W  = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    output logic [7:0]        bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs_n
);
    logic             eng_busy, start, ptr_clr, bus_buf_we, eng_we;
    logic [7:0]       opcode, tx_count, rx_count, buf_rdata, eng_rdata, eng_wdata;
    logic [SEL_W-1:0] cs_sel;
    logic [IDX_W-1:0] bus_buf_idx, eng_rd_idx, eng_wr_idx;

    spi_cmd_regs #(.DEPTH(DEPTH), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .busy(eng_busy),
        .opcode(opcode), .tx_count(tx_count), .rx_count(rx_count),
        .cs_sel(cs_sel), .start(start), .ptr_clr(ptr_clr),
        .buf_we(bus_buf_we), .buf_idx(bus_buf_idx), .buf_rdata(buf_rdata)
    );

    spi_cmd_fifo #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(eng_we || bus_buf_we),
        .wr_idx(eng_we ? eng_wr_idx : bus_buf_idx),
        .wr_data(eng_we ? eng_wdata : bus_wdata),
        .rd_a_idx(bus_buf_idx), .rd_a_data(buf_rdata),
        .rd_b_idx(eng_rd_idx), .rd_b_data(eng_rdata)
    );

    spi_cmd_engine #(.DEPTH(DEPTH), .CLK_DIV(CLK_DIV), .NUM_CS(NUM_CS)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .ptr_clr(ptr_clr),
        .opcode(opcode), .tx_count(tx_count), .rx_count(rx_count),
        .cs_sel(cs_sel), .busy(eng_busy), .rd_idx(eng_rd_idx),
        .rd_data(eng_rdata), .wr_en(eng_we), .wr_idx(eng_wr_idx),
        .wr_data(eng_wdata), .sclk(spi_sclk), .mosi(spi_mosi),
        .miso(spi_miso), .cs_n(spi_cs_n)
    );
endmodule

// File: rtl/spi_opcode_master_chk.sv
// Protocol checker for spi_opcode_master, attached by bind.
module spi_opcode_master_chk #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_we,
    input logic              busy,
    input logic              spi_sclk,
    input logic              spi_mosi,
    input logic [NUM_CS-1:0] spi_cs_n
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (spi_cs_n == '1) && !spi_sclk && spi_mosi); // R1
    AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk && $past(spi_sclk) |-> $stable(spi_mosi)); // R2
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && (bus_addr == 8'h02) && bus_wdata[0] && !busy |=> busy); // R6
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $countones(~spi_cs_n) == 1); // R8
    AST_SELECT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(spi_cs_n)); // R8
    AST_SCLK_UNDER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> spi_cs_n != '1); // R9
endmodule

bind spi_opcode_master spi_opcode_master_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .busy(eng_busy), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
);

// File: tb/spi_opcode_master_bench.sv
module spi_opcode_master_bench;
    localparam int DEPTH = 64;
    localparam int CLK_DIV = 4;

    logic       clk = 0, rst_n = 0, bus_we = 0, spi_miso = 0;
    logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
    logic       spi_sclk, spi_mosi;
    logic [3:0] spi_cs_n;

    spi_opcode_master u_spi_opcode_master (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    always #4 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0, bit_idx = 0, salt = 0, cs_bad = 0;
    int t_cs_fall, t_cs_rise, t_rise0, t_rise1, t_last_fall;
    logic [3:0] exp_cs = 4'hF;
    logic [7:0] cap [512];
    logic [7:0] mdl [DEPTH];
    int mptr = 0;
    logic cs_act;
    assign cs_act = spi_cs_n != 4'hF;

    function automatic logic [7:0] resp_byte(int k);
        return 8'(k * 29 + salt);
    endfunction

    always @(posedge clk) cyc++;

    // SPI slave model: capture data-out on rising edges, drive data-in on falling.
    always @(posedge cs_act) begin
        bit_idx = 0; t_cs_fall = cyc;
        spi_miso = resp_byte(0)[7];
    end
    always @(negedge cs_act) t_cs_rise = cyc;
    always @(posedge spi_sclk) begin
        if (bit_idx == 0) t_rise0 = cyc;
        if (bit_idx == 1) t_rise1 = cyc;
        if (spi_cs_n != exp_cs) cs_bad++;
        if (bit_idx / 8 < 512) cap[bit_idx / 8][7 - bit_idx % 8] = spi_mosi;
        bit_idx++;
    end
    always @(negedge spi_sclk) begin
        t_last_fall = cyc;
        if (cs_act) spi_miso = resp_byte(bit_idx / 8)[7 - bit_idx % 8];
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk); bus_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic check_buffer(input string req);
        logic [7:0] v;
        int bad = 0, first = -1;
        for (int i = 0; i < DEPTH; i++) begin
            rd(8'(8'h80 + i), v);
            if (v !== mdl[i]) begin bad++; if (first < 0) first = i; end
        end
        chk(bad == 0, req, "buffer readback mismatches (first index)", first, -1);
    endtask

    // One command with model update and all per-command checks.
    task automatic run_cmd(input logic [7:0] op, input int tx, input int rx,
                           input int sel, input bit clr, input bit poke);
        logic [7:0] v, exp;
        int p, nbad_tx = 0, nbad_rx = 0, wait_n = 0;
        salt = int'($urandom % 256);
        exp_cs = ~(4'b1 << sel);
        wr(8'h1D, 8'(sel)); wr(8'h00, op); wr(8'h48, 8'(tx)); wr(8'h4B, 8'(rx));
        for (int i = 0; i < tx && i < DEPTH; i++) begin
            v = 8'($urandom); mdl[i] = v; wr(8'(8'h80 + i), v);
        end
        if (clr) mptr = 0;
        cs_bad = 0;
        wr(8'h02, clr ? 8'h11 : 8'h01);
        rd(8'h03, v); chk(v[7] == 1'b1, "R5", "busy after start", v, 8'h80);
        rd(8'h02, v); chk(v == 8'h00, "R6", "pulse bits read back", v, 0);
        if (poke) begin
            repeat (10) @(negedge clk);
            wr(8'h02, 8'h11);              // R6: start and clear while busy ignored
            wr(8'h80, ~mdl[0]);            // R11: buffer write while busy ignored
        end
        do begin rd(8'h03, v); wait_n++; end while (v[7] && wait_n < 40000);
        chk(v[7] == 1'b0, "R5", "busy clear at end", v, 0);
        repeat (2) @(negedge clk);
        // expected stream and buffer update
        p = mptr;
        chk(cap[0] == op, "R2", "opcode byte", cap[0], op);
        for (int i = 0; i < tx; i++) begin
            exp = (p < DEPTH) ? mdl[p] : 8'hFF;
            if (cap[1 + i] !== exp) nbad_tx++;
            if (p < DEPTH) p++;
        end
        chk(nbad_tx == 0, (tx > DEPTH - mptr) ? "R10" : "R3", "send-byte mismatches", nbad_tx, 0);
        for (int j = 0; j < rx; j++) begin
            if (cap[1 + tx + j] !== 8'hFF) nbad_rx++;
            if (p < DEPTH) begin mdl[p] = resp_byte(1 + tx + j); p++; end
        end
        mptr = p;
        chk(nbad_rx == 0, "R4", "data-out high in reply phase", nbad_rx, 0);
        chk(bit_idx == 8 * (1 + tx + rx), "R9", "rising edge count", bit_idx, 8 * (1 + tx + rx));
        chk(t_rise1 - t_rise0 == CLK_DIV, "R9", "serial clock period", t_rise1 - t_rise0, CLK_DIV);
        chk(t_rise0 - t_cs_fall >= CLK_DIV, "R9", "select lead", t_rise0 - t_cs_fall, CLK_DIV);
        chk(t_cs_rise - t_last_fall >= CLK_DIV, "R9", "select lag", t_cs_rise - t_last_fall, CLK_DIV);
        chk(cs_bad == 0, "R8", "wrong select pattern at edges", cs_bad, 0);
        check_buffer((rx + tx > DEPTH) ? "R10" : (clr ? "R4" : "R7"));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) mdl[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk(spi_cs_n == 4'hF && !spi_sclk && spi_mosi, "R1", "idle pins", {spi_cs_n, spi_sclk, spi_mosi}, 8'h3D);
        rd(8'h00, v); chk(v == 0, "R1", "opcode reset", v, 0);
        rd(8'h03, v); chk(v == 0, "R1", "busy reset", v, 0);
        rd(8'h48, v); chk(v == 0, "R1", "send count reset", v, 0);
        rd(8'h4B, v); chk(v == 0, "R1", "reply count reset", v, 0);
        rd(8'h1D, v); chk(v == 0, "R1", "select reset", v, 0);
        check_buffer("R1");
        // directed cases
        run_cmd(8'h9F, 0, 3, 0, 1, 0);     // opcode then replies only (R4)
        run_cmd(8'h02, 4, 0, 1, 1, 0);     // send only (R3)
        run_cmd(8'h0B, 5, 6, 2, 1, 1);     // start while busy ignored (R6, R11)
        run_cmd(8'h03, 2, 2, 3, 0, 0);     // no pointer reset: continues (R7)
        run_cmd(8'h05, 0, 0, 3, 1, 0);     // opcode alone
        run_cmd(8'hA5, 60, 8, 1, 1, 0);    // replies overflow the buffer (R10)
        run_cmd(8'h5A, 70, 0, 0, 1, 0);    // sends beyond the buffer as 0xFF (R10)
        // constrained random commands
        for (int n = 0; n < 16; n++) begin
            run_cmd(8'($urandom), int'($urandom % 21), int'($urandom % 21),
                    int'($urandom % 4), ($urandom % 4) != 0, 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule